// File: doc/BRIEF.md
# RS error pattern byte corrector

This block applies Reed-Solomon error corrections to a page that sits in a byte-addressable buffer. The buffer holds 2112 bytes: 2048 bytes of page data, followed directly by 64 spare-area bytes, all in one linear address space. An error locator upstream sends the block a short stream of (symbol position, 12-bit error pattern) pairs. The last pair in the stream is marked. Each position names a 12-bit symbol in a packed stream that runs across bytes. Most symbols therefore cover parts of two bytes. One symbol crosses from the data page into the spare area.

The block first collects the whole stream and checks every pair. If any pair cannot be corrected, it raises a fail flag and writes nothing to the buffer. Otherwise it updates every affected byte with a read-modify-write XOR through a simple synchronous RAM port, and reports how many symbols it corrected. Syndrome computation and error location are done outside this block.

Top module: `rs_byte_fixer`

## Requirements
- R1: For an odd position p, with b = floor(3p/2), byte b is XORed with pattern bits 11..4 and byte b+1 is XORed with pattern bits 3..0 placed in its upper nibble (mask = {pat[3:0], 4'h0}).
- R2: For an even nonzero position p, with b = 3p/2, byte b-1 is XORed with pattern bits 11..8 in its lower nibble (mask = {4'h0, pat[11:8]}) and byte b is XORed with pattern bits 7..0.
- R3: For position 0, only byte 0 is touched, and it is XORed with pattern bits 7..0.
- R4: At position 0, a pattern above 0xFF makes the whole page uncorrectable.
- R5: Any position above 1374 makes the whole page uncorrectable.
- R6: The spare area occupies linear addresses 2048..2111. Position 1365 updates data byte 2047 and spare byte 0 (address 2048). Positions 1366..1374 update only spare bytes. No RAM access goes outside 0..2111.
- R7: If a page is uncorrectable, no RAM write happens for that page, `fail` reads 1 and `fixed_count` reads 0 while `done` is high.
- R8: When a page is corrected, `done` pulses for exactly one cycle with `fail` = 0 and `fixed_count` equal to the number of pairs in the stream. The block returns to idle in the next cycle.
- R9: A stream that carries more than 4 pairs (the maximum number of symbol errors) is uncorrectable.
- R10: While `busy` is high, pairs offered on the input are ignored. They change neither the buffer nor the result of the next page.
- R11: Each updated byte takes one read cycle (`ram_rd_en`, with data returned on `ram_rdata` one cycle later), followed at once by one write cycle to the same address. `busy` rises in the cycle after the last pair is accepted and stays high through the `done` cycle. An uncorrectable page is busy for exactly one cycle.
- R12: Pairs are applied one after another in stream order. Two symbols that share a byte both take effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pair is offered on in_pos/in_pat |
| in_last | input | 1 | The offered pair ends the page's stream |
| in_pos | input | 11 | Symbol position |
| in_pat | input | 12 | Error pattern for that symbol |
| busy | output | 1 | A page is being judged or corrected; input is ignored |
| ram_rd_en | output | 1 | Buffer read strobe |
| ram_wr_en | output | 1 | Buffer write strobe |
| ram_addr | output | 12 | Buffer byte address |
| ram_wdata | output | 8 | Corrected byte to write |
| ram_rdata | input | 8 | Buffer read data, one cycle after the read strobe |
| done | output | 1 | One-cycle end-of-page pulse |
| fail | output | 1 | Page was uncorrectable (valid with done) |
| fixed_count | output | 3 | Symbols corrected (valid with done) |

## Verification
Two things can happen in the same cycle: the correction engine can be writing a byte back while the input side is offered new pairs, including a pair that ends a stream. The bench provokes this by holding the input valid during a correction, with pairs that would touch fresh bytes if they were taken. It judges the result in two ways: its cycle-accurate model ignores those pairs, and a full comparison of the buffer after the page shows that nothing was applied. A second overlap is the write of one symbol's shared byte followed at once by the read of that same byte for the next symbol. The bench provokes it with adjacent odd and even positions and checks the combined XOR.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;

    localparam int POS_W       = 11;
    localparam int PAT_W       = 12;
    localparam int DATA_BYTES  = 2048;
    localparam int SPARE_BYTES = 64;
    localparam int BUF_BYTES   = DATA_BYTES + SPARE_BYTES;
    localparam int ADDR_W      = $clog2(BUF_BYTES);
    localparam int MAX_POS     = 1374;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [PAT_W-1:0] pat;
    } err_pair_t;

    // Up to two byte updates derived from one symbol
    typedef struct packed {
        logic [ADDR_W-1:0] addr0;
        logic [7:0]        mask0;
        logic [ADDR_W-1:0] addr1;
        logic [7:0]        mask1;
        logic              pair;
        logic              bad;
    } byte_fix_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } eng_state_t;

    function automatic logic pair_is_bad(err_pair_t e);
        logic over_range;
        logic wide_first;
        over_range = (e.pos > POS_W'(MAX_POS));
        wide_first = (e.pos == '0) && (|e.pat[PAT_W-1:8]);
        return over_range || wide_first;
    endfunction

    function automatic byte_fix_t map_pair(err_pair_t e);
        byte_fix_t         f;
        logic [ADDR_W+1:0] tri3;
        logic [ADDR_W-1:0] base;
        tri3 = {3'b000, e.pos} + {2'b00, e.pos, 1'b0};
        base = tri3[ADDR_W:1];
        f = '0;
        if (e.pos == '0) begin
            f.addr0 = '0;
            f.mask0 = e.pat[7:0];
            f.pair  = 1'b0;
        end else if (e.pos[0]) begin
            f.addr0 = base;
            f.mask0 = e.pat[11:4];
            f.addr1 = base + ADDR_W'(1);
            f.mask1 = {e.pat[3:0], 4'h0};
            f.pair  = 1'b1;
        end else begin
            f.addr0 = base - ADDR_W'(1);
            f.mask0 = {4'h0, e.pat[11:8]};
            f.addr1 = base;
            f.mask1 = e.pat[7:0];
            f.pair  = 1'b1;
        end
        f.bad = pair_is_bad(e);
        return f;
    endfunction

endpackage

// File: rtl/fixer_collect.sv
module fixer_collect
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int CNT_W   = $clog2(MAX_ERR + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  err_pair_t        in_pair,
    input  logic             busy,
    output err_pair_t        slots [MAX_ERR],
    output logic             start,
    output logic [CNT_W-1:0] start_cnt,
    output logic             start_bad
);

    logic [CNT_W-1:0] cnt_q;
    logic             bad_q;
    logic             take;
    logic             full;
    logic             in_bad;

    assign take   = in_valid && !busy;
    assign full   = (cnt_q == CNT_W'(MAX_ERR));
    assign in_bad = pair_is_bad(in_pair);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bad_q <= 1'b0;
        end else if (take) begin
            if (in_last) begin
                cnt_q <= '0;
                bad_q <= 1'b0;
            end else begin
                if (!full) cnt_q <= cnt_q + CNT_W'(1);
                bad_q <= bad_q | in_bad | full;
            end
        end
    end

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[g] <= '0;
            else if (take && !full && cnt_q == CNT_W'(g))
                slots[g] <= in_pair;
        end
    end

    assign start     = take && in_last;
    assign start_cnt = full ? cnt_q : cnt_q + CNT_W'(1);
    assign start_bad = bad_q | in_bad | full;

    // R9
    cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_ERR));

    // R10
    ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy) |=> ($stable(cnt_q) && $stable(bad_q)));

endmodule

// File: rtl/fixer_map.sv
module fixer_map
    import rsfix_pkg::*;
#(
    parameter int N = 4
) (
    input  err_pair_t pairs [N],
    output byte_fix_t fixes [N]
);

    for (genvar g = 0; g < N; g++) begin : g_map
        assign fixes[g] = map_pair(pairs[g]);
    end

endmodule

// File: rtl/fixer_engine.sv
module fixer_engine
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int CNT_W   = $clog2(MAX_ERR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              start_bad,
    input  byte_fix_t         fixes [MAX_ERR],
    output logic              busy,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  fixed_count
);

    localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

    eng_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             half_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fail_q;
    logic [CNT_W-1:0] count_q;
    byte_fix_t        cur;
    logic [7:0]       cur_mask;
    logic             last_idx;

    assign cur      = fixes[idx_q];
    assign ram_addr = half_q ? cur.addr1 : cur.addr0;
    assign cur_mask = half_q ? cur.mask1 : cur.mask0;
    assign last_idx = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

    assign ram_rd_en   = (state_q == ST_READ);
    assign ram_wr_en   = (state_q == ST_WRITE);
    assign ram_wdata   = ram_rdata ^ cur_mask;
    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);
    assign fail        = fail_q;
    assign fixed_count = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            half_q  <= 1'b0;
            cnt_q   <= '0;
            fail_q  <= 1'b0;
            count_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    cnt_q   <= start_cnt;
                    idx_q   <= '0;
                    half_q  <= 1'b0;
                    fail_q  <= start_bad;
                    count_q <= start_bad ? '0 : start_cnt;
                    state_q <= start_bad ? ST_DONE : ST_READ;
                end
                ST_READ: state_q <= ST_WRITE;
                ST_WRITE: begin
                    if (!half_q && cur.pair) begin
                        half_q  <= 1'b1;
                        state_q <= ST_READ;
                    end else if (last_idx) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        half_q  <= 1'b0;
                        state_q <= ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R11
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        ram_wr_en |-> ($past(ram_rd_en) && ram_addr == $past(ram_addr)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R7
    fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (fixed_count == '0));

    // R7
    bad_never_applied_chk: assert property (@(posedge clk) disable iff (rst)
        ram_rd_en |-> (!cur.bad && !fail_q));

endmodule

// File: rtl/rs_byte_fixer.sv
module rs_byte_fixer
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    localparam int CNT_W  = $clog2(MAX_ERR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [POS_W-1:0]  in_pos,
    input  logic [PAT_W-1:0]  in_pat,
    output logic              busy,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  fixed_count
);

    err_pair_t        in_pair;
    err_pair_t        slots [MAX_ERR];
    byte_fix_t        fixes [MAX_ERR];
    logic             start;
    logic [CNT_W-1:0] start_cnt;
    logic             start_bad;

    assign in_pair.pos = in_pos;
    assign in_pair.pat = in_pat;

    fixer_collect #(.MAX_ERR(MAX_ERR), .CNT_W(CNT_W)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_pair   (in_pair),
        .busy      (busy),
        .slots     (slots),
        .start     (start),
        .start_cnt (start_cnt),
        .start_bad (start_bad)
    );

    fixer_map #(.N(MAX_ERR)) u_map (
        .pairs (slots),
        .fixes (fixes)
    );

    fixer_engine #(.MAX_ERR(MAX_ERR), .CNT_W(CNT_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_cnt   (start_cnt),
        .start_bad   (start_bad),
        .fixes       (fixes),
        .busy        (busy),
        .ram_rd_en   (ram_rd_en),
        .ram_wr_en   (ram_wr_en),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .ram_rdata   (ram_rdata),
        .done        (done),
        .fail        (fail),
        .fixed_count (fixed_count)
    );

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_rd_en || ram_wr_en) |-> (ram_addr < ADDR_W'(BUF_BYTES)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ram_rd_en && !ram_wr_en));

endmodule

// File: tb/test_rs_byte_fixer.sv
module test_rs_byte_fixer;

    localparam int NBUF = 2112;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [10:0] in_pos = '0;
    logic [11:0] in_pat = '0;
    logic        busy, ram_rd_en, ram_wr_en, done, fail;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [2:0]  fixed_count;

    logic [7:0] mem     [NBUF];
    logic [7:0] exp_mem [NBUF];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rem = 0;
    int exp_cnt = 0;
    bit exp_fail = 0;
    bit finished = 0;
    int q_pos[$];
    int q_pat[$];

    always #4 clk = ~clk;

    rs_byte_fixer i_rs_byte_fixer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_pos(in_pos), .in_pat(in_pat), .busy(busy),
        .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .done(done),
        .fail(fail), .fixed_count(fixed_count)
    );

    // Synchronous buffer RAM, one-cycle read latency
    always @(posedge clk) begin
        if (ram_wr_en) mem[int'(ram_addr)] <= ram_wdata;
        if (ram_rd_en) ram_rdata <= mem[int'(ram_addr)];
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cycles);
        end
    endtask

    task automatic xor_byte(input int a, input int m);
        exp_mem[a] = exp_mem[a] ^ 8'(m);
    endtask

    // Reference model: judge the page and apply it to the expected buffer
    task automatic judge_page();
        int nbytes = 0;
        bit bad = (q_pos.size() > 4);
        foreach (q_pos[i]) begin
            if (q_pos[i] > 1374) bad = 1;
            if (q_pos[i] == 0 && q_pat[i] > 255) bad = 1;
        end
        if (!bad) begin
            foreach (q_pos[i]) begin
                int p = q_pos[i];
                int t = q_pat[i];
                if (p == 0) begin
                    xor_byte(0, t & 255);
                    nbytes += 1;
                end else if (p % 2 == 1) begin
                    xor_byte(3 * p / 2, t >> 4);
                    xor_byte(3 * p / 2 + 1, (t & 15) << 4);
                    nbytes += 2;
                end else begin
                    xor_byte(3 * p / 2 - 1, t >> 8);
                    xor_byte(3 * p / 2, t & 255);
                    nbytes += 2;
                end
            end
        end
        exp_fail = bad;
        exp_cnt  = bad ? 0 : q_pos.size();
        rem      = bad ? 1 : 2 * nbytes + 1;
        q_pos.delete();
        q_pat.delete();
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            rem = 0;
            q_pos.delete();
            q_pat.delete();
        end else begin
            chk(busy == (rem > 0), "R11 busy window", busy, rem > 0);
            chk(done == (rem == 1), "R8 done pulse", done, rem == 1);
            if (rem == 1) begin
                chk(fail == exp_fail, "R7/R4/R5/R9 fail flag", fail, exp_fail);
                chk(int'(fixed_count) == exp_cnt, "R8/R7 fixed_count", fixed_count, exp_cnt);
            end
            if (rem == 0)
                chk(!ram_rd_en && !ram_wr_en, "R10 RAM quiet when idle", ram_rd_en | ram_wr_en, 0);
            if (rem > 0) begin
                rem--;
            end else if (in_valid) begin
                q_pos.push_back(int'(in_pos));
                q_pat.push_back(int'(in_pat));
                if (in_last) judge_page();
            end
        end
    end

    task automatic drive(input bit v, input bit l, input int p, input int t);
        @(posedge clk);
        #1;
        in_valid = v;
        in_last  = l;
        in_pos   = 11'(p);
        in_pat   = 12'(t);
    endtask

    task automatic wait_idle();
        drive(0, 0, 0, 0);
        repeat (2) @(posedge clk);
        while (rem > 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic cmp_buf(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < NBUF; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0)
            chk(0, $sformatf("%s buffer byte %0d", req, first), mem[first], exp_mem[first]);
        else
            chk(1, req, 0, 0);
    endtask

    task automatic page(input int n, input int p [6], input int t [6], input string req);
        for (int i = 0; i < n; i++) drive(1, i == n - 1, p[i], t[i]);
        wait_idle();
        cmp_buf(req);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NBUF; i++) begin
            mem[i]     = 8'((i * 7 + 3) % 256);
            exp_mem[i] = 8'((i * 7 + 3) % 256);
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail && fixed_count == 0, "R8 reset state",
            {busy, done, fail}, 0);
        // R1 odd position
        page(1, '{1, 0, 0, 0, 0, 0}, '{12'hABC, 0, 0, 0, 0, 0}, "R1 odd position");
        // R2 even position
        page(1, '{10, 0, 0, 0, 0, 0}, '{12'h5E7, 0, 0, 0, 0, 0}, "R2 even position");
        // R3 position zero narrow pattern
        page(1, '{0, 0, 0, 0, 0, 0}, '{12'h05A, 0, 0, 0, 0, 0}, "R3 position zero");
        // R4 position zero wide pattern, with a good pair before it
        page(2, '{7, 0, 0, 0, 0, 0}, '{12'h111, 12'h1FF, 0, 0, 0, 0}, "R4 wide first symbol");
        // R6 boundary straddle and spare positions
        page(3, '{1365, 1366, 1374, 0, 0, 0}, '{12'hF0F, 12'h3C5, 12'h9A6, 0, 0, 0},
             "R6 spare boundary");
        // R5 out-of-range position among good ones
        page(3, '{3, 1375, 9, 0, 0, 0}, '{12'h222, 12'h333, 12'h444, 0, 0, 0},
             "R5 position above limit");
        // R12 adjacent symbols sharing byte 2, R8 count of four
        page(4, '{1, 2, 100, 0, 0, 0}, '{12'hFFF, 12'h801, 12'h0F0, 12'h0C3, 0, 0},
             "R12 shared byte");
        // R9 five pairs
        page(5, '{20, 21, 22, 23, 24, 0}, '{1, 2, 3, 4, 5, 0}, "R9 too many pairs");
        // R10 pairs offered while busy are ignored
        drive(1, 1, 501, 12'h777);
        drive(1, 0, 600, 12'hABC);
        drive(1, 1, 602, 12'h123);
        drive(1, 1, 0, 12'h0FF);
        wait_idle();
        cmp_buf("R10 input ignored while busy");
        // R8 back-to-back pages after busy-time stimulus
        page(2, '{1364, 1373, 0, 0, 0, 0}, '{12'h0A5, 12'h5A0, 0, 0, 0, 0}, "R8 follow-on page");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule